// File: doc/BRIEF.md
# NOR Flash Program/Erase Status Controller

This block models the command and status logic of a NOR flash device on top of a small register array. A host issues single-cycle bus writes that form short command sequences: a word program, an erase of any chosen set of sectors, or an erase of the whole array. While an operation runs, bus reads return a status word instead of array data, and a ready output is held low. When the operation ends, the block returns to array reads by itself.

An erase walks through three phases. It first drives every word of the chosen sectors to zero, then waits out an erase interval, then writes all ones and reads each word back to verify it. An erase may be suspended. While suspended, ready is high, words outside the chosen sectors read as normal array data, and a resume command continues the erase from where it stopped. Program and erase times are parameters counted in clock cycles.

Command byte (bits 7:0 of the write data): 0xA0 arms a program, and the next write supplies the address and data. 0x80 arms an erase. After it, 0x30 adds the sector of its address to the erase set, 0x48 starts the erase, and 0x10 starts a whole-array erase. 0xB0 suspends a running erase and 0x30 resumes a suspended one. With the defaults there are 64 words of 16 bits, and the sector is given by address bits 5:4.

Top module: `flash_status_ctrl`

## Requirements
- R1: After reset, ready is 1, rd_data is 0 and every array word reads 0xFFFF.
- R2: A program (0xA0, then address and data) leaves the word equal to old AND data. Bits can only go from 1 to 0. Ready is low for exactly PROG_CYCLES cycles, counted from the clock edge that takes the data write.
- R3: A read during a program returns a status word. Bit 7 is the complement of bit 7 of the data being written, and every bit other than 6 is 0.
- R4: Bit 6 of the status word flips on each read while ready is low. Once the operation ends, repeated reads return identical array data.
- R5: With no reset command, the first read after ready rises returns array data.
- R6: Ready is low while an operation is active and not suspended. It is high when the block is idle or suspended.
- R7: A sector erase sets every word of the chosen sectors to 0xFFFF and leaves all other sectors unchanged. Status bit 7 reads 0 throughout the erase.
- R8: Command 0x10 given after 0x80 erases every word of the array.
- R9: 0xB0 during an erase halts it, and ready stays high for as long as the block is suspended. Reads outside the chosen sectors return array data. Reads inside them return status with bit 7 at 0 and bit 6 unchanged between reads. 0x30 resumes the erase.
- R10: Writes while an operation is active are ignored, apart from 0xB0 during an erase. While suspended, every write except 0x30 is ignored.
- R11: After 0x80, any code other than 0x30, 0x10 or 0x48 returns to array reads with no operation started. A 0x48 with an empty erase set starts nothing.
- R12: An erase keeps ready low for 3*WORDS + ERASE_CYCLES active cycles in total. A suspend does not change this total.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_cs | input | 1 | Chip select; qualifies reads and writes |
| bus_we | input | 1 | Write strobe, one cycle per command write |
| bus_re | input | 1 | Read strobe; data appears on rd_data after the next edge |
| bus_addr | input | AW (6) | Word address |
| bus_wdata | input | DW (16) | Write data; bits 7:0 carry the command byte |
| rd_data | output | DW (16) | Registered read data or status word |
| ready | output | 1 | High when idle or suspended, low while an operation runs |

## Verification
The hardest state to reach is a suspended erase that sits partway through its phase walk. This is the only time the status and array paths are mixed, chosen per address. The bench starts an erase on one sector and waits a fixed number of cycles, so the suspend lands in the pre-program phase. It then reads one word inside and one word outside the chosen sector, tries a program command that must be ignored, and resumes. It counts the active cycles on both sides of the suspension and checks that they add up to the full erase length.

// File: rtl/flash_ctrl_pkg.sv
package flash_ctrl_pkg;
  typedef enum logic [2:0] {
    OP_IDLE, OP_PROG, OP_PRE, OP_ERASE, OP_FILL, OP_VERIFY
  } op_e;

  typedef enum logic [1:0] {
    SEQ_READ, SEQ_PSETUP, SEQ_ESETUP
  } seq_e;

  localparam logic [7:0] CMD_PROG_ARM  = 8'hA0;
  localparam logic [7:0] CMD_ERASE_ARM = 8'h80;
  localparam logic [7:0] CMD_ALL       = 8'h10;
  localparam logic [7:0] CMD_MARK      = 8'h30;
  localparam logic [7:0] CMD_LAUNCH    = 8'h48;
  localparam logic [7:0] CMD_HALT      = 8'hB0;
  localparam logic [7:0] CMD_CONTINUE  = 8'h30;
endpackage

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_ctrl_pkg::*;
#(
  parameter int NSECT   = 4,
  parameter int SECT_AW = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_stb,
  input  logic [7:0]         wr_cmd,
  input  logic [SECT_AW-1:0] wr_sect,
  input  logic               eng_active,
  input  logic               eng_erasing,
  input  logic               eng_susp,
  output logic               prog_go,
  output logic               erase_go,
  output logic [NSECT-1:0]   erase_set,
  output logic               susp_go,
  output logic               resume_go
);
  seq_e             seq_q, seq_d;
  logic [NSECT-1:0] mark_q, mark_d;
  logic [NSECT-1:0] sect_bit;

  assign sect_bit = NSECT'(1) << wr_sect;

  always_comb begin
    seq_d     = seq_q;
    mark_d    = mark_q;
    prog_go   = 1'b0;
    erase_go  = 1'b0;
    erase_set = mark_q;
    susp_go   = 1'b0;
    resume_go = 1'b0;
    if (wr_stb) begin
      if (eng_susp) begin
        resume_go = (wr_cmd == CMD_CONTINUE);
      end else if (eng_active) begin
        susp_go = eng_erasing && (wr_cmd == CMD_HALT);
      end else begin
        case (seq_q)
          SEQ_READ: begin
            if (wr_cmd == CMD_PROG_ARM) begin
              seq_d = SEQ_PSETUP;
            end else if (wr_cmd == CMD_ERASE_ARM) begin
              seq_d  = SEQ_ESETUP;
              mark_d = '0;
            end
          end
          SEQ_PSETUP: begin
            prog_go = 1'b1;
            seq_d   = SEQ_READ;
          end
          SEQ_ESETUP: begin
            if (wr_cmd == CMD_ALL) begin
              erase_go  = 1'b1;
              erase_set = '1;
              seq_d     = SEQ_READ;
            end else if (wr_cmd == CMD_MARK) begin
              mark_d = mark_q | sect_bit;
            end else if (wr_cmd == CMD_LAUNCH) begin
              erase_go = |mark_q;
              seq_d    = SEQ_READ;
            end else begin
              seq_d = SEQ_READ;
            end
          end
          default: seq_d = SEQ_READ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q  <= SEQ_READ;
      mark_q <= '0;
    end else begin
      seq_q  <= seq_d;
      mark_q <= mark_d;
    end
  end
endmodule

// File: rtl/flash_op_engine.sv
module flash_op_engine
  import flash_ctrl_pkg::*;
#(
  parameter int AW           = 6,
  parameter int DW           = 16,
  parameter int NSECT        = 4,
  parameter int SECT_AW      = 2,
  parameter int PROG_CYCLES  = 6,
  parameter int ERASE_CYCLES = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_go,
  input  logic [AW-1:0]    prog_addr,
  input  logic [DW-1:0]    prog_data,
  input  logic             erase_go,
  input  logic [NSECT-1:0] erase_set_in,
  input  logic             susp_go,
  input  logic             resume_go,
  input  logic [DW-1:0]    mem_rd,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_val,
  output logic             mem_and,
  output logic             active,
  output logic             erasing,
  output logic             suspended,
  output logic             programming,
  output logic             prog_bit7,
  output logic [NSECT-1:0] erase_set
);
  localparam int MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);
  localparam logic [AW-1:0] IDX_ONE = AW'(1);

  op_e              op_q, op_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [AW-1:0]    idx_q, idx_d;
  logic [NSECT-1:0] set_q, set_d;
  logic [AW-1:0]    pa_q, pa_d;
  logic [DW-1:0]    pd_q, pd_d;
  logic             susp_q, susp_d;
  logic             idx_hit, idx_last;

  assign idx_hit  = set_q[idx_q[AW-1 -: SECT_AW]];
  assign idx_last = &idx_q;

  always_comb begin
    op_d     = op_q;
    cnt_d    = cnt_q;
    idx_d    = idx_q;
    set_d    = set_q;
    pa_d     = pa_q;
    pd_d     = pd_q;
    susp_d   = susp_q;
    mem_we   = 1'b0;
    mem_addr = idx_q;
    mem_val  = '0;
    mem_and  = 1'b1;
    if (susp_q) begin
      if (resume_go) susp_d = 1'b0;
    end else begin
      case (op_q)
        OP_IDLE: begin
          if (prog_go) begin
            op_d  = OP_PROG;
            cnt_d = CW'(PROG_CYCLES - 1);
            pa_d  = prog_addr;
            pd_d  = prog_data;
          end else if (erase_go) begin
            op_d  = OP_PRE;
            idx_d = '0;
            set_d = erase_set_in;
          end
        end
        OP_PROG: begin
          if (cnt_q == '0) begin
            mem_we   = 1'b1;
            mem_addr = pa_q;
            mem_val  = pd_q;
            op_d     = OP_IDLE;
          end else begin
            cnt_d = cnt_q - CNT_ONE;
          end
        end
        OP_PRE: begin
          mem_we = idx_hit;
          idx_d  = idx_q + IDX_ONE;
          if (idx_last) begin
            op_d  = OP_ERASE;
            cnt_d = CW'(ERASE_CYCLES - 1);
          end
        end
        OP_ERASE: begin
          if (cnt_q == '0) begin
            op_d  = OP_FILL;
            idx_d = '0;
          end else begin
            cnt_d = cnt_q - CNT_ONE;
          end
        end
        OP_FILL: begin
          mem_we  = idx_hit;
          mem_val = '1;
          mem_and = 1'b0;
          idx_d   = idx_q + IDX_ONE;
          if (idx_last) op_d = OP_VERIFY;
        end
        OP_VERIFY: begin
          if (idx_hit && (mem_rd != '1)) begin
            op_d  = OP_FILL;
            idx_d = '0;
          end else begin
            idx_d = idx_q + IDX_ONE;
            if (idx_last) op_d = OP_IDLE;
          end
        end
        default: op_d = OP_IDLE;
      endcase
      if (susp_go && (op_d != OP_IDLE)) susp_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      set_q  <= '0;
      pa_q   <= '0;
      pd_q   <= '0;
      susp_q <= 1'b0;
    end else begin
      op_q   <= op_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      set_q  <= set_d;
      pa_q   <= pa_d;
      pd_q   <= pd_d;
      susp_q <= susp_d;
    end
  end

  assign erasing     = (op_q == OP_PRE) || (op_q == OP_ERASE) ||
                       (op_q == OP_FILL) || (op_q == OP_VERIFY);
  assign programming = (op_q == OP_PROG);
  assign active      = (op_q != OP_IDLE) && !susp_q;
  assign suspended   = susp_q;
  assign prog_bit7   = pd_q[7];
  assign erase_set   = set_q;
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wval,
  input  logic          and_mode,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] nxt;

  assign nxt = and_mode ? (mem[waddr] & wval) : wval;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[w] <= '1;
      end else if (we && (waddr == AW'(w))) begin
        mem[w] <= nxt;
      end
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/flash_read_path.sv
module flash_read_path #(
  parameter int DW      = 16,
  parameter int NSECT   = 4,
  parameter int SECT_AW = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_stb,
  input  logic [SECT_AW-1:0] rd_sect,
  input  logic [DW-1:0]      arr_data,
  input  logic               active,
  input  logic               suspended,
  input  logic               programming,
  input  logic               prog_bit7,
  input  logic [NSECT-1:0]   erase_set,
  output logic [DW-1:0]      rd_data
);
  logic          tog_q;
  logic [DW-1:0] rdata_q, rdata_d, status;
  logic          show_status;

  assign show_status = active || (suspended && erase_set[rd_sect]);

  always_comb begin
    status    = '0;
    status[7] = programming ? ~prog_bit7 : 1'b0;
    status[6] = tog_q;
    rdata_d   = show_status ? status : arr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q   <= 1'b0;
      rdata_q <= '0;
    end else if (rd_stb) begin
      rdata_q <= rdata_d;
      if (active) tog_q <= ~tog_q;
    end
  end

  assign rd_data = rdata_q;
endmodule

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl #(
  parameter int AW           = 6,
  parameter int DW           = 16,
  parameter int SECT_AW      = 2,
  parameter int PROG_CYCLES  = 6,
  parameter int ERASE_CYCLES = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_cs,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] rd_data,
  output logic          ready
);
  localparam int NSECT = 1 << SECT_AW;

  logic [1:0]         rst_pipe;
  logic               rst_s;
  logic               wr_stb, rd_stb;
  logic [SECT_AW-1:0] bus_sect;
  logic               prog_go, erase_go, susp_go, resume_go;
  logic [NSECT-1:0]   cmd_set, erase_set;
  logic               active, erasing, susp, programming, prog_bit7;
  logic               mem_we, mem_and;
  logic [AW-1:0]      mem_addr;
  logic [DW-1:0]      mem_val, mem_rd, arr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  assign wr_stb   = bus_cs && bus_we;
  assign rd_stb   = bus_cs && bus_re;
  assign bus_sect = bus_addr[AW-1 -: SECT_AW];

  flash_cmd_seq #(.NSECT(NSECT), .SECT_AW(SECT_AW)) u_seq (
    .clk(clk), .rst_n(rst_s), .wr_stb(wr_stb), .wr_cmd(bus_wdata[7:0]),
    .wr_sect(bus_sect), .eng_active(active), .eng_erasing(erasing),
    .eng_susp(susp), .prog_go(prog_go), .erase_go(erase_go),
    .erase_set(cmd_set), .susp_go(susp_go), .resume_go(resume_go)
  );

  flash_op_engine #(
    .AW(AW), .DW(DW), .NSECT(NSECT), .SECT_AW(SECT_AW),
    .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) u_eng (
    .clk(clk), .rst_n(rst_s), .prog_go(prog_go), .prog_addr(bus_addr),
    .prog_data(bus_wdata), .erase_go(erase_go), .erase_set_in(cmd_set),
    .susp_go(susp_go), .resume_go(resume_go), .mem_rd(mem_rd),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_val(mem_val),
    .mem_and(mem_and), .active(active), .erasing(erasing),
    .suspended(susp), .programming(programming), .prog_bit7(prog_bit7),
    .erase_set(erase_set)
  );

  flash_array #(.AW(AW), .DW(DW)) u_arr (
    .clk(clk), .rst_n(rst_s), .we(mem_we), .waddr(mem_addr),
    .wval(mem_val), .and_mode(mem_and), .raddr_a(bus_addr),
    .rdata_a(arr_data), .raddr_b(mem_addr), .rdata_b(mem_rd)
  );

  flash_read_path #(.DW(DW), .NSECT(NSECT), .SECT_AW(SECT_AW)) u_rd (
    .clk(clk), .rst_n(rst_s), .rd_stb(rd_stb), .rd_sect(bus_sect),
    .arr_data(arr_data), .active(active), .suspended(susp),
    .programming(programming), .prog_bit7(prog_bit7),
    .erase_set(erase_set), .rd_data(rd_data)
  );

  assign ready = !active;
endmodule

// File: rtl/flash_status_ctrl_chk.sv
module flash_status_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_go,
  input logic       rd_go,
  input logic [7:0] wr_cmd,
  input logic [1:0] poll_bits,
  input logic       ready,
  input logic       susp,
  input logic       erasing
);
  AST_START_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(wr_go)); // R2

  AST_SUSPEND_ON_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(susp) |-> $past(wr_go && (wr_cmd == 8'hB0))); // R9

  AST_SUSPEND_READY: assert property (@(posedge clk) disable iff (!rst_n)
    susp |-> ready); // R6

  AST_ERASE_POLL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && !ready && erasing) |=> !poll_bits[1]); // R7

  AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && !ready) ##1 (rd_go && !ready) |=> (poll_bits[0] != $past(poll_bits[0]))); // R4
endmodule

bind flash_status_ctrl flash_status_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_s), .wr_go(wr_stb), .rd_go(rd_stb),
  .wr_cmd(bus_wdata[7:0]), .poll_bits(rd_data[7:6]), .ready(ready),
  .susp(susp), .erasing(erasing)
);

// File: tb/sim_flash_status_ctrl.sv
module sim_flash_status_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6, DW = 16, SECT_AW = 2;
  localparam int PROG_CYCLES = 6, ERASE_CYCLES = 20;
  localparam int WORDS = 1 << AW;
  localparam int ERASE_LEN = 3 * WORDS + ERASE_CYCLES;
  localparam int NVEC = 6;
  localparam logic [21:0] VEC [NVEC] = '{
    {6'd3, 16'hF0F0}, {6'd3, 16'h3C3C}, {6'd20, 16'h1234},
    {6'd37, 16'h00FF}, {6'd58, 16'h8001}, {6'd5, 16'h7F7F}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_cs = 1'b0, bus_we = 1'b0, bus_re = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] rd_data;
  logic ready;
  logic [DW-1:0] ref_mem [WORDS];
  int n_chk = 0, n_bad = 0;

  flash_status_ctrl #(.AW(AW), .DW(DW), .SECT_AW(SECT_AW),
    .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
    .bus_re(bus_re), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_data(rd_data), .ready(ready));

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_cs = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    bus_cs = 1'b1; bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_cs = 1'b0; bus_re = 1'b0;
    d = rd_data;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (!ready) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic scan(input string req);
    logic [DW-1:0] v;
    for (int a = 0; a < WORDS; a++) begin
      rd(AW'(a), v);
      chk(v == ref_mem[a], req, v, ref_mem[a]);
    end
  endtask

  task automatic erase_ref(input int sect);
    for (int a = 0; a < WORDS; a++)
      if ((a >> (AW - SECT_AW)) == sect) ref_mem[a] = '1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] v, v2;
    int n, n1;
    for (int a = 0; a < WORDS; a++) ref_mem[a] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk(ready == 1'b1, "R1 ready", {15'd0, ready}, 16'd1);
    chk(rd_data == '0, "R1 rd_data", rd_data, 16'h0000);
    rd(6'd9, v);
    chk(v == 16'hFFFF, "R1 erased word", v, 16'hFFFF);

    // table of program vectors: R2 R3 R4 R5 R6
    for (int i = 0; i < NVEC; i++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d, exp_st;
      a = VEC[i][21:16];
      d = VEC[i][15:0];
      wr(6'd0, 16'h00A0);
      wr(a, d);
      chk(ready == 1'b0, "R6 busy after start", {15'd0, ready}, 16'd0);
      rd(a, v);
      exp_st = '0;
      exp_st[7] = ~d[7];
      chk((v & ~16'h0040) == exp_st, "R3 program status", v, exp_st);
      rd(a, v2);
      chk(v2[6] != v[6], "R4 toggle during program", v2, v ^ 16'h0040);
      wait_idle(n);
      chk(n == PROG_CYCLES - 2, "R2 program length", 16'(n), 16'(PROG_CYCLES - 2));
      ref_mem[a] = ref_mem[a] & d;
      rd(a, v);
      chk(v == ref_mem[a], "R5 read after program", v, ref_mem[a]);
      rd(a, v2);
      chk(v2 == v, "R4 no toggle when idle", v2, v);
    end

    // R10: writes while busy are ignored
    wr(6'd0, 16'h00A0);
    wr(6'd10, 16'hFF0F);
    wr(6'd0, 16'h00A0);
    wr(6'd11, 16'h0000);
    wait_idle(n);
    ref_mem[10] = ref_mem[10] & 16'hFF0F;
    wr(6'd11, 16'h0000);
    chk(ready == 1'b1, "R10 stray write no start", {15'd0, ready}, 16'd1);
    rd(6'd11, v);
    chk(v == ref_mem[11], "R10 ignored program", v, ref_mem[11]);
    rd(6'd10, v);
    chk(v == ref_mem[10], "R2 program during busy test", v, ref_mem[10]);

    // R11: aborted and empty erase setups
    wr(6'd0, 16'h0080);
    wr(6'd0, 16'h0055);
    wr(6'd16, 16'h0030);
    chk(ready == 1'b1, "R11 abort no start", {15'd0, ready}, 16'd1);
    wr(6'd0, 16'h0080);
    wr(6'd0, 16'h0048);
    chk(ready == 1'b1, "R11 empty set no start", {15'd0, ready}, 16'd1);

    // R7 R12: erase sectors 1 and 3
    wr(6'd0, 16'h0080);
    wr(6'd16, 16'h0030);
    wr(6'd48, 16'h0030);
    wr(6'd0, 16'h0048);
    rd(6'd3, v);
    chk(v[7] == 1'b0, "R7 erase poll bit7", v, 16'h0000);
    chk((v & ~16'h0040) == '0, "R7 erase status word", v, 16'h0000);
    rd(6'd3, v2);
    chk(v2[6] != v[6], "R4 toggle during erase", v2, v ^ 16'h0040);
    wait_idle(n);
    chk(n == ERASE_LEN - 2, "R12 erase length", 16'(n), 16'(ERASE_LEN - 2));
    erase_ref(1);
    erase_ref(3);
    scan("R7 sector erase contents");

    // R9 R10 R12: suspend an erase of sector 2
    wr(6'd0, 16'h0080);
    wr(6'd37, 16'h0030);
    wr(6'd0, 16'h0048);
    repeat (10) @(negedge clk);
    wr(6'd0, 16'h00B0);
    chk(ready == 1'b1, "R9 ready high in suspend", {15'd0, ready}, 16'd1);
    rd(6'd3, v);
    chk(v == ref_mem[3], "R9 read outside set", v, ref_mem[3]);
    rd(6'd37, v);
    chk(v[7] == 1'b0, "R9 status inside set", v, 16'h0000);
    rd(6'd37, v2);
    chk(v2 == v, "R9 bit6 held in suspend", v2, v);
    wr(6'd0, 16'h00A0);
    wr(6'd5, 16'h0000);
    repeat (30) @(negedge clk);
    chk(ready == 1'b1, "R9 erase halted", {15'd0, ready}, 16'd1);
    rd(6'd5, v);
    chk(v == ref_mem[5], "R10 program ignored in suspend", v, ref_mem[5]);
    wr(6'd0, 16'h0030);
    chk(ready == 1'b0, "R9 resume", {15'd0, ready}, 16'd0);
    wait_idle(n1);
    chk(n1 + 11 == ERASE_LEN, "R12 total with suspend", 16'(n1 + 11), 16'(ERASE_LEN));
    erase_ref(2);
    scan("R9 contents after resume");

    // R8: whole-array erase
    wr(6'd0, 16'h0080);
    wr(6'd0, 16'h0010);
    wait_idle(n);
    chk(n == ERASE_LEN, "R12 chip erase length", 16'(n), 16'(ERASE_LEN));
    for (int s = 0; s < (1 << SECT_AW); s++) erase_ref(s);
    scan("R8 chip erase contents");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule